// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block watches a bank of already-synchronized input pins and turns selected pin conditions into interrupt flags. Each pin owns one control word on a simple 32-bit register bus; a 4-bit mode field in that word picks what the pin reports: nothing, a low level, a high level, a rising edge, a falling edge, or either edge.

Detected conditions latch into one shared flag word. Software reads it, services the pins it finds set, and acknowledges them by writing ones to the same word. A single interrupt line to the parent controller is high whenever any flag is set. Edge modes compare each pin with its value from the previous clock. Level modes keep re-raising the flag for as long as the pin stays at its active level.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every control word reads 0, the flag word (address 0xA0) reads 0 and irq_o is low.
- R2: A write to the control word at address 4*n stores write-data bits 19:16 as pin n's mode. A read returns that mode in bits 19:16 and zeros in every other bit.
- R3: Mode 0x9 (rising) sets pin n's flag in the clock cycle after the pin goes from 0 to 1. A pin held at 1 does not set the flag again, and a 1-to-0 change does not set it.
- R4: Mode 0xA (falling) sets the flag after a 1-to-0 change and ignores 0-to-1 changes.
- R5: Mode 0xB (either edge) sets the flag after any change of the pin.
- R6: Mode 0xC sets the flag while the pin is 1, and mode 0x8 sets it while the pin is 0. Clearing the flag while the pin is still at its active level leaves it set.
- R7: Mode 0x0 (this includes a control word written with 0) and the unused codes 0x1 to 0x7 and 0xD to 0xF never set a flag, whatever the pin does.
- R8: A write to address 0xA0 clears exactly the flags whose write-data bit is 1. Flags whose bit is 0 keep their value, and writing all ones clears every flag.
- R9: When a pin condition and a clear write hit the same flag in the same cycle, the flag ends up set.
- R10: irq_o is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, qualified by bus_sel_i |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pin_i | input | 32 | Synchronized pin levels |
| irq_o | output | 1 | Aggregated interrupt to the parent |

## Verification
The bench aims at the cases where a plausible implementation goes wrong. A rising-edge pin left high after its flag is cleared must stay quiet; an edge detector that is really a level detector would raise the flag again. A level pin cleared while it is still active must stay flagged; a design that drops it would lose the interrupt. The bench also programs unused mode codes and a zeroed control word and then toggles the pin; a decoder that checks only part of the field would raise flags there. A clear and a fresh edge land in the same cycle, which catches clear-over-set priority, because a design with that priority loses a single-shot edge for good. A partial acknowledge must leave its neighbour's flag and the interrupt line standing.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_BOTH = 4'hB,
    MODE_HIGH = 4'hC
  } irq_mode_e;

  // True for the five codes that can raise a flag.
  function automatic logic mode_armed(input logic [MODE_W-1:0] mode);
    case (mode)
      MODE_LOW, MODE_RISE, MODE_FALL, MODE_BOTH, MODE_HIGH: return 1'b1;
      default:                                              return 1'b0;
    endcase
  endfunction

  // Condition for one pin, from its current and previous level.
  function automatic logic pin_event(input logic [MODE_W-1:0] mode,
                                     input logic cur, input logic prev);
    case (mode)
      MODE_LOW:  return ~cur;
      MODE_HIGH: return cur;
      MODE_RISE: return cur & ~prev;
      MODE_FALL: return ~cur & prev;
      MODE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pinirq_cfg.sv
module pinirq_cfg
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [MODE_W-1:0]                wr_mode_i,
  output logic [NUM_PINS-1:0][MODE_W-1:0]  mode_o,
  output logic [NUM_PINS-1:0]              armed_o
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        mode_o[i] <= MODE_OFF;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        mode_o[i] <= wr_mode_i;
      end
    end
    assign armed_o[i] = mode_armed(mode_o[i]);
  end

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PINS-1:0]             pin_i,
  input  logic [NUM_PINS-1:0][MODE_W-1:0] mode_i,
  output logic [NUM_PINS-1:0]             evt_o
);

  logic [NUM_PINS-1:0] pin_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_evt
    assign evt_o[i] = pin_event(mode_i[i], pin_i[i], pin_q[i]);
  end

endmodule

// File: rtl/pinirq_flags.sv
module pinirq_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flags_o
);

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MODE_LSB  = 16,
  parameter int FLAG_ADDR = 'hA0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                irq_o
);

  localparam int IDX_W     = $clog2(NUM_PINS);
  localparam int CTRL_SPAN = NUM_PINS * 4;

  logic                            ctrl_hit, flag_hit, wr_stb;
  logic [IDX_W-1:0]                ctrl_idx;
  logic [NUM_PINS-1:0][MODE_W-1:0] pin_mode;
  logic [NUM_PINS-1:0]             mode_armed_v;
  logic [NUM_PINS-1:0]             pin_evt;
  logic [NUM_PINS-1:0]             clr_vec;
  logic [NUM_PINS-1:0]             flag_q;
  logic [1:0]                      unused_addr_lsb;

  assign wr_stb          = bus_sel_i & bus_wr_i;
  assign ctrl_hit        = bus_addr_i < ADDR_W'(CTRL_SPAN);
  assign flag_hit        = bus_addr_i == ADDR_W'(FLAG_ADDR);
  assign ctrl_idx        = bus_addr_i[IDX_W+1:2];
  assign unused_addr_lsb = bus_addr_i[1:0];
  assign clr_vec         = (wr_stb && flag_hit) ? bus_wdata_i[NUM_PINS-1:0] : '0;

  pinirq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_stb & ctrl_hit),
    .wr_idx_i  (ctrl_idx),
    .wr_mode_i (bus_wdata_i[MODE_LSB +: MODE_W]),
    .mode_o    (pin_mode),
    .armed_o   (mode_armed_v)
  );

  pinirq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .mode_i (pin_mode),
    .evt_o  (pin_evt)
  );

  pinirq_flags #(.NUM_PINS(NUM_PINS)) u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (pin_evt),
    .clr_i   (clr_vec),
    .flags_o (flag_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (ctrl_hit)      bus_rdata_o[MODE_LSB +: MODE_W] = pin_mode[ctrl_idx];
    else if (flag_hit) bus_rdata_o[NUM_PINS-1:0]       = flag_q;
  end

  assign irq_o = |flag_q;

endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] clr,
  input logic [NUM_PINS-1:0] flags,
  input logic [NUM_PINS-1:0] armed
);

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == '0 && !irq));

  // R7: only an armed mode may produce a condition
  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~armed) == '0);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((flags & $past(clr & ~evt)) == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags ^ $past(flags)) & ~$past(evt | clr)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> irq);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);

endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .irq   (irq_o),
  .evt   (pin_evt),
  .clr   (clr_vec),
  .flags (flag_q),
  .armed (mode_armed_v)
);

// File: tb/sim_pinirq_ctrl.sv
module sim_pinirq_ctrl;

  localparam logic [7:0] FLAGS = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  typedef struct {
    string       tag;
    logic [7:0]  a;
    logic [31:0] exp;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  pinirq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .irq_o(irq)
  );

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic setp(input int idx, input logic v);
    @(negedge clk); pins[idx] = v;
  endtask

  task automatic pin_and_clear(input int idx, input logic v, input logic [31:0] m);
    @(negedge clk); pins[idx] = v; sel = 1'b1; wr = 1'b1; addr = FLAGS; wdata = m;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  // Driver: put the address on the bus and push the expected item.
  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] e);
    item_t it;
    @(negedge clk); addr = a;
    it.tag = tag; it.a = a; it.exp = e;
    q.push_back(it);
  endtask

  // Monitor: compares just after the falling edge.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
        end
        if (it.a == FLAGS) begin
          checks++;
          if (irq !== (it.exp != 0)) begin
            fails++;
            $display("FAIL R10 irq actual=%b expected=%b", irq, (it.exp != 0));
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    expect_rd("R1 flags", FLAGS, 32'h0);
    expect_rd("R1 ctrl5", 8'h14, 32'h0);
    // R2
    wreg(8'h0C, 32'hFFFF_FFFF);
    expect_rd("R2 field only", 8'h0C, 32'h000F_0000);
    wreg(8'h0C, 32'h0009_0000);
    expect_rd("R2 readback", 8'h0C, 32'h0009_0000);
    // R3 rising on pin 3
    setp(3, 1'b1);
    expect_rd("R3 rise", FLAGS, 32'h8);
    wreg(FLAGS, 32'h8);
    expect_rd("R3 held high", FLAGS, 32'h0);
    setp(3, 1'b0);
    expect_rd("R3 fall ignored", FLAGS, 32'h0);
    // R4 falling on pin 7
    wreg(8'h1C, 32'h000A_0000);
    setp(7, 1'b1);
    expect_rd("R4 rise ignored", FLAGS, 32'h0);
    setp(7, 1'b0);
    expect_rd("R4 fall", FLAGS, 32'h80);
    wreg(FLAGS, 32'h80);
    // R5 either edge on pin 10
    wreg(8'h28, 32'h000B_0000);
    setp(10, 1'b1);
    expect_rd("R5 rise", FLAGS, 32'h400);
    wreg(FLAGS, 32'h400);
    expect_rd("R5 cleared", FLAGS, 32'h0);
    setp(10, 1'b0);
    expect_rd("R5 fall", FLAGS, 32'h400);
    wreg(FLAGS, 32'h400);
    // R6 level high on pin 12
    wreg(8'h30, 32'h000C_0000);
    setp(12, 1'b1);
    expect_rd("R6 high", FLAGS, 32'h1000);
    wreg(FLAGS, 32'h1000);
    expect_rd("R6 high persists", FLAGS, 32'h1000);
    setp(12, 1'b0);
    wreg(FLAGS, 32'h1000);
    expect_rd("R6 high released", FLAGS, 32'h0);
    // R6 level low on pin 13 (pin already low)
    wreg(8'h34, 32'h0008_0000);
    expect_rd("R6 low", FLAGS, 32'h2000);
    setp(13, 1'b1);
    wreg(FLAGS, 32'h2000);
    expect_rd("R6 low released", FLAGS, 32'h0);
    // R7 unused codes and masking on pin 20
    wreg(8'h50, 32'h0005_0000);
    setp(20, 1'b1); setp(20, 1'b0);
    expect_rd("R7 code 5", FLAGS, 32'h0);
    wreg(8'h50, 32'h000D_0000);
    expect_rd("R7 readback D", 8'h50, 32'h000D_0000);
    setp(20, 1'b1); setp(20, 1'b0);
    expect_rd("R7 code D", FLAGS, 32'h0);
    wreg(8'h50, 32'h000B_0000);
    wreg(8'h50, 32'h0);
    setp(20, 1'b1); setp(20, 1'b0);
    expect_rd("R7 masked", FLAGS, 32'h0);
    // R8 selective clear
    setp(3, 1'b1); setp(10, 1'b1);
    expect_rd("R8 two flags", FLAGS, 32'h408);
    wreg(FLAGS, 32'h8);
    expect_rd("R8 one cleared", FLAGS, 32'h400);
    wreg(FLAGS, 32'h0);
    expect_rd("R8 zero write", FLAGS, 32'h400);
    wreg(FLAGS, 32'hFFFF_FFFF);
    expect_rd("R8 all cleared", FLAGS, 32'h0);
    // R9 set wins over clear
    setp(3, 1'b0);
    wreg(FLAGS, 32'hFFFF_FFFF);
    expect_rd("R9 pre", FLAGS, 32'h0);
    pin_and_clear(3, 1'b1, 32'h8);
    expect_rd("R9 set wins", FLAGS, 32'h8);
    wreg(FLAGS, 32'h8);
    expect_rd("R10 quiet", FLAGS, 32'h0);
    @(negedge clk); #5;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule